// File: doc/BRIEF.md
# Dual-Reference Baud Tick Generator

This block produces the timing strobes that a serial transmitter and receiver use. It emits a one-cycle strobe at sixteen times the bit rate, and a second strobe once per bit period. Both run in the system clock domain. Two reference clocks are represented by enable pulses: a slow reference near 1.8432 MHz and a fast one at 24 MHz. The block counts pulses from whichever reference is selected. When the programmed count is reached, it fires the oversample strobe and starts counting again.

The divisor is a 16-bit value that is written one byte at a time. Its most significant bit selects the fast reference when it is 1 and the slow reference when it is 0. The remaining 15 bits give the number of reference pulses per oversample strobe. The two divisor bytes appear in a small register window only while a bank-select bit is set in the line-control register. At other times those addresses belong to other functions of the serial port, which are not part of this block.

The oversample rate equals the reference frequency divided by 16 and by the count. On the fast reference, the count is therefore 1,500,000 divided by the baud rate: 13 gives about 115200 baud and 26 gives about 57600 baud. On the slow reference, 1 gives 115200, 12 gives 9600 and 2304 gives 50 baud.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0x0001 (slow reference, count 1), the bank-select bit is 0, and both strobes are low.
- R2: The low divisor byte is at offset 0 and the high byte is at offset 1. A write to either offset changes the divisor only while the bank-select bit is 1. When the bit is 0, the write leaves the divisor and the strobe timing unchanged.
- R3: Divisor bit 15 = 1 selects `fast_ref_en` as the counted reference, and bit 15 = 0 selects `slow_ref_en`. Pulses on the reference that is not selected have no effect.
- R4: `baud_x16` is high for the one cycle after the edge that samples the Nth selected reference pulse since the last strobe or reload. N is divisor bits [14:0].
- R5: A count field of zero behaves exactly like a count of 1.
- R6: An accepted divisor byte write restarts both the count and the bit phase. A reference pulse sampled on the same edge as that write is not counted.
- R7: `baud_bit` is high together with every 16th `baud_x16` pulse since reset or the last reload.
- R8: `baud_x16` goes high only in the cycle after an edge at which the selected reference pulse was present.
- R9: `baud_bit` is never high without `baud_x16`.
- R10: Bit 7 of offset 3 holds the bank-select bit and is writable and readable. `rd_data` returns the addressed register one cycle after `rd_addr` is presented. Offsets 0 and 1 read as the divisor bytes when the bank-select bit is 1 and as 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Registered read data |
| slow_ref_en | input | 1 | Enable pulse of the slow reference |
| fast_ref_en | input | 1 | Enable pulse of the 24 MHz reference |
| baud_x16 | output | 1 | Oversample strobe, sixteen per bit |
| baud_bit | output | 1 | Bit-rate strobe |

## Verification
The assertions assume that reference enables arrive only as system-clock-wide levels sampled at rising edges. They also assume that a divisor write and a counted pulse on the same edge resolve in favour of the write. The stimulus drives every input on the falling edge. It keeps both enables low during register accesses, so the expected strobe times depend only on pulses issued in stepping cycles. The enable patterns are chosen so that the reference that is not selected keeps toggling while the selected one runs. A count of zero is driven with an enable in every cycle, which shows that back-to-back strobes are legal.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_ADDR_W = 3;
  localparam int REG_DATA_W = 8;
  localparam logic [REG_ADDR_W-1:0] OFS_DIV_LO = 3'd0;
  localparam logic [REG_ADDR_W-1:0] OFS_LINE   = 3'd3;
  localparam int BANK_BIT = 7;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_pkg::*;
#(
  parameter int ADDR_W    = REG_ADDR_W,
  parameter int DATA_W    = REG_DATA_W,
  parameter int DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o
);
  localparam int LANES = DIV_W / DATA_W;

  logic [DATA_W-1:0] lane_q [LANES];
  logic [LANES-1:0]  lane_hit;
  logic              bank_q;

  // line-control register: only the bank-select bit lives here
  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == OFS_LINE) bank_q <= wr_data_i[BANK_BIT];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = wr_en_i && bank_q && (wr_addr_i == OFS_DIV_LO + ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (rst) lane_q[g] <= DIV_RESET[g*DATA_W +: DATA_W];
      else if (lane_hit[g]) lane_q[g] <= wr_data_i;
    end
    assign div_o[g*DATA_W +: DATA_W] = lane_q[g];
  end

  assign load_o = |lane_hit;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == OFS_LINE) rd_mux[BANK_BIT] = bank_q;
    for (int i = 0; i < LANES; i++)
      if (bank_q && rd_addr_i == OFS_DIV_LO + ADDR_W'(i)) rd_mux = lane_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  // R2: with the bank closed, no write can alter the divisor
  a_r2_bank_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !bank_q) |=> $stable(div_o));
  // R6: a reload pulse only comes from an open bank
  a_r6_load_needs_bank: assert property (@(posedge clk) disable iff (rst)
    load_o |-> (bank_q && wr_en_i));
endmodule

// File: rtl/baud_ref_sel.sv
module baud_ref_sel (
  input  logic sel_fast_i,
  input  logic slow_en_i,
  input  logic fast_en_i,
  output logic ref_en_o
);
  assign ref_en_o = sel_fast_i ? fast_en_i : slow_en_i;
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int CNT_W = 15,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ref_en_i,
  input  logic             load_i,
  output logic             tick_o,
  output logic             bit_o
);
  localparam int SUB_W = $clog2(OVS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SUB_W-1:0] sub_q;

  // a zero count runs as one so the strobe never stalls
  assign lim = (count_i == '0) ? CNT_W'(1) : count_i;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      tick_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      bit_o  <= 1'b0;
      if (ref_en_i) begin
        if (cnt_q >= lim - CNT_W'(1)) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
          bit_o  <= (sub_q == SUB_W'(OVS-1));
          sub_q  <= (sub_q == SUB_W'(OVS-1)) ? '0 : sub_q + SUB_W'(1);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R8: a strobe follows a sampled reference pulse
  a_r8_tick_needs_ref: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(ref_en_i));
  // R9: bit strobe only coincides with an oversample strobe
  a_r9_bit_with_tick: assert property (@(posedge clk) disable iff (rst)
    bit_o |-> tick_o);
  // R6: a reload leaves the next cycle quiet
  a_r6_reload_quiet: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !tick_o);
  // R4: without a reload the count never passes its limit
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> (cnt_q < lim || $changed(count_i)));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              slow_ref_en,
  input  logic              fast_ref_en,
  output logic              baud_x16,
  output logic              baud_bit
);
  localparam int CNT_W = DIV_W - 1;

  logic [DIV_W-1:0] div;
  logic             load;
  logic             ref_en;

  baud_div_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
                  .DIV_RESET(DIV_W'(1))) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .div_o(div), .load_o(load));

  baud_ref_sel u_sel (
    .sel_fast_i(div[DIV_W-1]), .slow_en_i(slow_ref_en),
    .fast_en_i(fast_ref_en), .ref_en_o(ref_en));

  baud_counter #(.CNT_W(CNT_W), .OVS(OVS)) u_cnt (
    .clk(clk), .rst(rst), .count_i(div[CNT_W-1:0]), .ref_en_i(ref_en),
    .load_i(load), .tick_o(baud_x16), .bit_o(baud_bit));

  // R3: while the fast source is selected, a strobe needs a fast pulse
  a_r3_fast_source: assert property (@(posedge clk) disable iff (rst)
    (baud_x16 && $past(div[DIV_W-1]) && !$past(load)) |-> $past(fast_ref_en));
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       slow_ref_en = 1'b0;
  logic       fast_ref_en = 1'b0;
  logic       baud_x16, baud_bit;

  baud_tick_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slow_ref_en(slow_ref_en),
    .fast_ref_en(fast_ref_en), .baud_x16(baud_x16), .baud_bit(baud_bit));

  always #5 clk = ~clk;

  typedef struct { int cyc; bit last; } exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [15:0] m_div = 16'h0001;
  logic        m_bank = 1'b0;
  int          m_cnt = 0;
  int          m_sub = 0;
  bit          monitor_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (monitor_on) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        check("R4 missed strobe", 0, q[0].cyc);
        void'(q.pop_front());
      end
      if (baud_x16) begin
        if (q.size() > 0 && q[0].cyc == cyc) begin
          check("R4 strobe time", cyc, q[0].cyc);
          check("R7 bit strobe", int'(baud_bit), int'(q[0].last));
          void'(q.pop_front());
        end else begin
          check("R8 unexpected strobe", 1, 0);
        end
      end else if (baud_bit) begin
        check("R9 bit without strobe", 1, 0);
      end
    end
  end

  // driver: one stepping cycle with given enables
  task automatic step(input logic s, input logic f);
    int lim;
    @(negedge clk);
    slow_ref_en = s;
    fast_ref_en = f;
    wr_en = 1'b0;
    lim = (m_div[14:0] == 0) ? 1 : int'(m_div[14:0]);   // R5
    if (m_div[15] ? f : s) begin                       // R3
      m_cnt++;
      if (m_cnt >= lim) begin
        m_cnt = 0;
        q.push_back('{cyc + 1, m_sub == 15});           // R7
        m_sub = (m_sub + 1) % 16;
      end
    end
  endtask

  task automatic run(input int n, input int slow_per, input int fast_per);
    for (int i = 0; i < n; i++)
      step(i % slow_per == 0, i % fast_per == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    slow_ref_en = 1'b0;
    fast_ref_en = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 3'd3) m_bank = d[7];
    else if (m_bank && a == 3'd0) begin m_div[7:0] = d; m_cnt = 0; m_sub = 0; end   // R6
    else if (m_bank && a == 3'd1) begin m_div[15:8] = d; m_cnt = 0; m_sub = 0; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    slow_ref_en = 1'b0;
    fast_ref_en = 1'b0;
    rd_addr = a;
    @(negedge clk);
    check(req, int'(rd_data), int'(exp));
  endtask

  initial begin
    #2_000_000;
    check("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 x16 low after reset", int'(baud_x16), 0);
    check("R1 bit low after reset", int'(baud_bit), 0);
    rd(3'd3, 8'h00, "R1 bank clear");
    rd(3'd0, 8'h00, "R10 divisor hidden when bank clear");
    monitor_on = 1'b1;

    // R1: reset divisor 1 on slow reference
    run(40, 2, 1);

    wr(3'd3, 8'h80);
    rd(3'd3, 8'h80, "R10 bank bit readback");
    rd(3'd0, 8'h01, "R1 reset low byte");
    rd(3'd1, 8'h00, "R1 reset high byte");

    // R2/R3: slow count 3, fast pulses every cycle ignored
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    rd(3'd0, 8'h03, "R2 low byte written");
    run(220, 2, 1);

    // R6: reload mid-period
    run(5, 1, 1);
    wr(3'd0, 8'h04);
    run(150, 3, 1);

    // R3: fast count 2, slow pulses ignored
    wr(3'd1, 8'h80);
    wr(3'd0, 8'h02);
    rd(3'd1, 8'h80, "R2 high byte written");
    run(120, 1, 2);

    // R5: zero count, fast enable every cycle
    wr(3'd0, 8'h00);
    run(40, 1, 1);
    run(30, 1, 3);

    // R2: bank closed, write ignored, timing unchanged
    wr(3'd3, 8'h00);
    rd(3'd0, 8'h00, "R10 hidden again");
    wr(3'd0, 8'h05);
    run(40, 1, 2);
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R2 ignored write kept low byte");
    rd(3'd1, 8'h80, "R2 ignored write kept high byte");

    repeat (4) step(1'b0, 1'b0);
    check("R4 all strobes seen", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule